// File: doc/BRIEF.md
# Little-endian variable-length instruction aligner

This block sits between instruction fetch and decode. It takes 32-bit fetch words from memory in little-endian byte order and delivers whole instructions of 16, 32, 48 or 64 bits, one at a time, each with a code giving its length. Incoming bytes collect in a small internal byte buffer. Within the current four-byte window, the length is taken from the half-word formed by bytes 3 and 2, because in little-endian order that half-word holds the major opcode. The instruction bytes are then put into decode order, and the bytes that were used are removed so that the next analysis starts on what is left.

In the extended mode, certain major opcodes mark short or long encodings. With the mode off, every instruction is a plain 32-bit word. A flush drops all buffered bytes at once, for example after a redirect. An instruction is only offered once all of its bytes are in the buffer.

Top module: `lea_aligner`

## Requirements
- R1: While reset is held and on the first cycle after it, `insn_valid` is 0 and `fetch_ready` is 1.
- R2: With `ext_mode` low, every instruction is 32 bits long. Its `insn_len` is 1, and `insn_data` bytes 0..3 carry buffer bytes 2,3,0,1, with the upper 32 bits zero. Length codes are 0=16, 1=32, 2=48, 3=64 bits.
- R3: The major opcode is bits 7:2 of window byte 3, which are the top six bits of the half-word built from bytes 3 and 2.
- R4: In extended mode, opcode 0 or 1 gives a 16-bit instruction. `insn_data[15:0]` is {byte3, byte2} and the rest is zero. Only bytes 2 and 3 are consumed. Bytes 0 and 1 stay at the front, and the following bytes move up to become the new bytes 2 and 3.
- R5: In extended mode, opcodes 2, 3, 56 and 57 give a 48-bit instruction. Output bytes 0..5 carry buffer bytes 2,3,0,1,4,5, and the upper 16 bits are zero. Six bytes are consumed.
- R6: In extended mode, opcodes 4, 5, 46 and 47 give a 64-bit instruction. Output bytes 0..7 carry buffer bytes 2,3,0,1,6,7,4,5. Eight bytes are consumed.
- R7: In extended mode, any other opcode gives a 32-bit instruction laid out as in R2. This includes the compressed-prefix opcodes 9 and 17 and their swizzle forms 6 and 7.
- R8: `insn_valid` is raised only when at least four bytes are buffered and every byte of the decoded instruction is present.
- R9: A fetch word is accepted whenever at least four buffer bytes are free. `fetch_ready` is high whenever no instruction is valid and no flush is active.
- R10: While `insn_valid` is high and `insn_ready` is low, the same instruction and length are held on the next cycle, unless a flush occurs or the mode changes.
- R11: During a flush cycle, `insn_valid` and `fetch_ready` are 0. The fetch word offered in that cycle is dropped, and the buffer is empty on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | Enables variable-length decoding |
| flush | input | 1 | Discards all buffered bytes |
| fetch_valid | input | 1 | Fetch word present |
| fetch_ready | output | 1 | Fetch word will be taken |
| fetch_data | input | 32 | Fetch word, lowest address in bits 7:0 |
| insn_valid | output | 1 | Complete instruction present |
| insn_ready | input | 1 | Decode takes the instruction |
| insn_len | output | 2 | Length code (0=16, 1=32, 2=48, 3=64 bits) |
| insn_data | output | 64 | Reordered instruction, unused upper bytes zero |

## Verification
The bench sends three kinds of stream. The first is a standard-mode stream that carries the short and long opcodes, which shows whether the mode gate is honoured. The second is a long extended-mode stream whose window opcodes cycle through every special value mixed with random bytes. It tells apart errors in the byte order of each length, in the middle-of-window removal after a 16-bit instruction, and in the point where analysis restarts. The third covers partial instructions, which must wait for more bytes or be wiped by a flush whose own fetch word is dropped. Holding decode off fills the buffer, which separates a correct ready limit and a correct hold of the offered instruction from a buffer that overruns or drops data.

// File: rtl/lea_pkg.sv
package lea_pkg;

  typedef enum logic [1:0] {
    ILEN_16 = 2'd0,
    ILEN_32 = 2'd1,
    ILEN_48 = 2'd2,
    ILEN_64 = 2'd3
  } ilen_e;

  localparam int MAX_INSN_BYTES = 8;
  localparam int WIN_BYTES      = 4;

  function automatic logic [3:0] ilen_bytes(input ilen_e l);
    case (l)
      ILEN_16: ilen_bytes = 4'd2;
      ILEN_32: ilen_bytes = 4'd4;
      ILEN_48: ilen_bytes = 4'd6;
      default: ilen_bytes = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/lea_len_decode.sv
module lea_len_decode
  import lea_pkg::*;
(
  input  logic       ext_mode,
  input  logic [7:0] opc_byte,
  output ilen_e      len
);

  logic [5:0] major;

  assign major = opc_byte[7:2];

  always_comb begin
    len = ILEN_32;
    if (ext_mode) begin
      case (major)
        6'd0, 6'd1:                len = ILEN_16;
        6'd2, 6'd3, 6'd56, 6'd57:  len = ILEN_48;
        6'd4, 6'd5, 6'd46, 6'd47:  len = ILEN_64;
        default:                   len = ILEN_32;
      endcase
    end
  end

endmodule

// File: rtl/lea_assemble.sv
module lea_assemble
  import lea_pkg::*;
(
  input  logic [MAX_INSN_BYTES-1:0][7:0] win,
  input  ilen_e                          len,
  output logic [63:0]                    insn
);

  always_comb begin
    case (len)
      ILEN_16: insn = {48'h0, win[3], win[2]};
      ILEN_32: insn = {32'h0, win[1], win[0], win[3], win[2]};
      ILEN_48: insn = {16'h0, win[5], win[4], win[1], win[0], win[3], win[2]};
      default: insn = {win[5], win[4], win[7], win[6],
                       win[1], win[0], win[3], win[2]};
    endcase
  end

endmodule

// File: rtl/lea_byte_buffer.sv
module lea_byte_buffer
  import lea_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int IN_BYTES  = 4,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int IDX_W    = $clog2(BUF_BYTES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           push,
  input  logic [8*IN_BYTES-1:0]          push_data,
  input  logic                           pop,
  input  ilen_e                          pop_len,
  output logic [MAX_INSN_BYTES-1:0][7:0] win,
  output logic [CNT_W-1:0]               count,
  output logic                           space_ok
);

  logic [BUF_BYTES-1:0][7:0] mem;
  logic [BUF_BYTES-1:0][7:0] shifted;
  logic [BUF_BYTES-1:0][7:0] mem_nxt;
  logic [CNT_W-1:0]          cnt_base;
  logic [CNT_W-1:0]          count_nxt;
  logic [3:0]                pbytes;
  logic                      mem_en;

  // Removal: a 16-bit pop takes bytes 2,3 out of the middle of the window.
  always_comb begin
    pbytes = pop ? ilen_bytes(pop_len) : 4'd0;
    for (int i = 0; i < BUF_BYTES; i++) begin
      int j;
      if (pop && pop_len == ILEN_16) j = (i < 2) ? i : i + 2;
      else                           j = i + int'(pbytes);
      shifted[i] = (j < BUF_BYTES) ? mem[IDX_W'((j < BUF_BYTES) ? j : 0)] : 8'h00;
    end
  end

  // Append the new fetch word behind the remaining bytes.
  always_comb begin
    cnt_base = count - CNT_W'(pbytes);
    mem_nxt  = shifted;
    for (int i = 0; i < BUF_BYTES; i++) begin
      for (int k = 0; k < IN_BYTES; k++) begin
        if (push && (i == int'(cnt_base) + k)) mem_nxt[i] = push_data[8*k +: 8];
      end
    end
    count_nxt = flush ? '0 : cnt_base + (push ? CNT_W'(IN_BYTES) : '0);
    mem_en    = push | pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  always_ff @(posedge clk) begin
    if (mem_en) mem <= mem_nxt;
  end

  genvar g;
  generate
    for (g = 0; g < MAX_INSN_BYTES; g++) begin : g_win
      assign win[g] = mem[g];
    end
  endgenerate

  assign space_ok = (int'(count) <= BUF_BYTES - IN_BYTES);

endmodule

// File: rtl/lea_aligner.sv
module lea_aligner
  import lea_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  localparam int IN_BYTES = 4,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_mode,
  input  logic        flush,
  input  logic        fetch_valid,
  output logic        fetch_ready,
  input  logic [31:0] fetch_data,
  output logic        insn_valid,
  input  logic        insn_ready,
  output logic [1:0]  insn_len,
  output logic [63:0] insn_data
);

  logic [MAX_INSN_BYTES-1:0][7:0] win;
  logic [CNT_W-1:0]               count;
  logic                           space_ok;
  ilen_e                          len;
  logic                           have_all;
  logic                           push;
  logic                           pop;

  lea_len_decode u_dec (
    .ext_mode (ext_mode),
    .opc_byte (win[3]),
    .len      (len)
  );

  lea_assemble u_asm (
    .win  (win),
    .len  (len),
    .insn (insn_data)
  );

  lea_byte_buffer #(
    .BUF_BYTES (BUF_BYTES),
    .IN_BYTES  (IN_BYTES)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .push_data (fetch_data),
    .pop       (pop),
    .pop_len   (len),
    .win       (win),
    .count     (count),
    .space_ok  (space_ok)
  );

  always_comb begin
    have_all    = (int'(count) >= WIN_BYTES) && (int'(count) >= int'(ilen_bytes(len)));
    insn_valid  = have_all & ~flush;
    fetch_ready = space_ok & ~flush;
    push        = fetch_valid & fetch_ready;
    pop         = insn_valid & insn_ready;
    insn_len    = len;
  end

endmodule

// File: rtl/lea_aligner_chk.sv
module lea_aligner_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ext_mode,
  input logic        flush,
  input logic        fetch_ready,
  input logic        insn_valid,
  input logic        insn_ready,
  input logic [1:0]  insn_len,
  input logic [63:0] insn_data
);

  a_r11_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!insn_valid && !fetch_ready));

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !insn_valid);

  a_r9_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_valid && !flush) |-> fetch_ready);

  a_r2_std_len: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !ext_mode) |-> (insn_len == 2'd1));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !insn_ready && !flush) |=>
      ((insn_valid && $stable(insn_data) && $stable(insn_len)) || flush || !$stable(ext_mode)));

  a_r4_short_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_len == 2'd0) |-> (insn_data[63:16] == 48'h0));

  a_r5_mid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_len == 2'd2) |-> (insn_data[63:48] == 16'h0));

endmodule

bind lea_aligner lea_aligner_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_mode    (ext_mode),
  .flush       (flush),
  .fetch_ready (fetch_ready),
  .insn_valid  (insn_valid),
  .insn_ready  (insn_ready),
  .insn_len    (insn_len),
  .insn_data   (insn_data)
);

// File: tb/tb_lea_aligner.sv
`timescale 1ns/1ps
module tb_lea_aligner;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_mode;
  logic        flush;
  logic        fetch_valid;
  logic        fetch_ready;
  logic [31:0] fetch_data;
  logic        insn_valid;
  logic        insn_ready;
  logic [1:0]  insn_len;
  logic [63:0] insn_data;

  always #2 clk = ~clk;

  lea_aligner dut (
    .clk (clk), .rst_n (rst_n), .ext_mode (ext_mode), .flush (flush),
    .fetch_valid (fetch_valid), .fetch_ready (fetch_ready), .fetch_data (fetch_data),
    .insn_valid (insn_valid), .insn_ready (insn_ready),
    .insn_len (insn_len), .insn_data (insn_data)
  );

  typedef struct { bit [1:0] len; bit [63:0] data; } item_t;

  int         checks = 0;
  int         fails  = 0;
  int         cyc    = 0;
  bit [7:0]   mq[$];
  item_t      eq[$];
  bit         ext_m  = 0;
  bit         hold_off = 0;
  bit [31:0]  rs  = 32'h1234_5678;
  bit [31:0]  rs2 = 32'h0bad_cafe;
  int         opi = 0;
  int         seen[4];
  bit [5:0]   oplist[16] = '{6'd0, 6'd2, 6'd1, 6'd4, 6'd3, 6'd5, 6'd56, 6'd57,
                             6'd46, 6'd47, 6'd6, 6'd7, 6'd9, 6'd17, 6'd30, 6'd63};

  function automatic bit [31:0] rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  task automatic chk(input bit ok, input string tag, input bit [63:0] act, input bit [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model from the requirements (R3..R7 decode, R4 middle removal)
  function automatic void model_run();
    while (mq.size() >= 4) begin
      bit [5:0]  op;
      bit [1:0]  lc;
      int        nb;
      item_t     it;
      op = mq[3][7:2];
      lc = 2'd1;
      if (ext_m) begin
        case (op)
          6'd0, 6'd1:               lc = 2'd0;
          6'd2, 6'd3, 6'd56, 6'd57: lc = 2'd2;
          6'd4, 6'd5, 6'd46, 6'd47: lc = 2'd3;
          default:                  lc = 2'd1;
        endcase
      end
      nb = 2 * (int'(lc) + 1);
      if (mq.size() < nb) break;
      it.len  = lc;
      it.data = '0;
      it.data[7:0]  = mq[2];
      it.data[15:8] = mq[3];
      if (lc != 2'd0) begin
        it.data[23:16] = mq[0];
        it.data[31:24] = mq[1];
      end
      if (lc == 2'd2) begin
        it.data[39:32] = mq[4];
        it.data[47:40] = mq[5];
      end
      if (lc == 2'd3) begin
        it.data[39:32] = mq[6];
        it.data[47:40] = mq[7];
        it.data[55:48] = mq[4];
        it.data[63:56] = mq[5];
      end
      if (lc == 2'd0) begin
        mq.delete(2);
        mq.delete(2);
      end else begin
        repeat (nb) void'(mq.pop_front());
      end
      eq.push_back(it);
    end
  endfunction

  function automatic bit [31:0] make_word();
    bit [31:0] w;
    int s;
    w = rnd();
    s = mq.size();
    if (s < 4) begin
      int p;
      p = 3 - s;
      w[8*p+2 +: 6] = oplist[opi % 16];
      opi++;
    end
    return w;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Driver: record the expected items, then hand the word to the design
  task automatic send_word(input bit [31:0] w);
    for (int b = 0; b < 4; b++) mq.push_back(w[8*b +: 8]);
    model_run();
    fetch_valid = 1'b1;
    fetch_data  = w;
    forever begin
      @(negedge clk);
      if (fetch_ready) break;
    end
    step();
    fetch_valid = 1'b0;
  endtask

  task automatic drain();
    for (int t = 0; t < 3000; t++) begin
      if (eq.size() == 0) break;
      step();
    end
    chk(eq.size() == 0, "R8 drain: pending items", 64'(eq.size()), 64'd0);
  endtask

  task automatic do_flush();
    flush = 1'b1;
    fetch_valid = 1'b1;
    fetch_data = rnd();
    @(negedge clk);
    chk(!insn_valid, "R11 valid during flush", 64'(insn_valid), 64'd0);
    chk(!fetch_ready, "R11 ready during flush", 64'(fetch_ready), 64'd0);
    step();
    flush = 1'b0;
    fetch_valid = 1'b0;
    @(negedge clk);
    chk(!insn_valid, "R11 valid after flush", 64'(insn_valid), 64'd0);
    mq.delete();
    step();
  endtask

  // Decode-side ready pattern
  always @(posedge clk) begin
    #1;
    rs2 ^= rs2 << 13; rs2 ^= rs2 >> 17; rs2 ^= rs2 << 5;
    insn_ready = hold_off ? 1'b0 : rs2[3];
  end

  // Monitor: compare each handshake against the scoreboard, and check holds
  bit        prev_hold = 0;
  bit [63:0] prev_data;
  bit [1:0]  prev_len;
  bit        prev_ext;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold && !flush && ext_mode == prev_ext) begin
        chk(insn_valid && insn_data == prev_data && insn_len == prev_len,
            "R10 held instruction", insn_data, prev_data);
      end
      prev_hold = insn_valid && !insn_ready && !flush;
      prev_data = insn_data;
      prev_len  = insn_len;
      prev_ext  = ext_mode;
      if (insn_valid && insn_ready) begin
        if (eq.size() == 0) begin
          chk(1'b0, "R8 unexpected instruction", insn_data, 64'd0);
        end else begin
          item_t e;
          string tg;
          e = eq.pop_front();
          case (e.len)
            2'd0: tg = "R4 R3 16-bit";
            2'd1: tg = ext_m ? "R7 R3 32-bit" : "R2 standard";
            2'd2: tg = "R5 R3 48-bit";
            default: tg = "R6 R3 64-bit";
          endcase
          chk(insn_len == e.len, {tg, " length"}, 64'(insn_len), 64'(e.len));
          chk(insn_data == e.data, {tg, " data"}, insn_data, e.data);
          seen[e.len]++;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_mode = 1'b0; flush = 1'b0;
    fetch_valid = 1'b0; fetch_data = '0; insn_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!insn_valid, "R1 valid in reset", 64'(insn_valid), 64'd0);
    chk(fetch_ready, "R1 ready in reset", 64'(fetch_ready), 64'd1);
    step();
    rst_n = 1'b1;
    @(negedge clk);
    chk(!insn_valid, "R1 valid after reset", 64'(insn_valid), 64'd0);
    chk(fetch_ready, "R1 ready after reset", 64'(fetch_ready), 64'd1);
    step();

    // Standard mode: special opcodes must not change the length (R2)
    ext_m = 0; ext_mode = 1'b0;
    for (int n = 0; n < 16; n++) send_word(make_word());
    drain();
    chk(mq.size() == 0, "R2 all bytes used", 64'(mq.size()), 64'd0);

    // Extended mode: mixed lengths (R3..R7)
    ext_m = 1; ext_mode = 1'b1;
    step();
    for (int n = 0; n < 80; n++) send_word(make_word());
    drain();
    do_flush();

    // Partial 64-bit instruction waits for its bytes (R8)
    send_word({8'h04 << 2, 24'h11_2233});
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      chk(!insn_valid, "R8 incomplete 64-bit held back", 64'(insn_valid), 64'd0);
    end
    step();
    send_word(32'h8899_aabb);
    drain();

    // Partial 48-bit then flush; the flush-cycle word must be lost (R11)
    send_word({8'h02 << 2, 24'h44_5566});
    @(negedge clk);
    chk(!insn_valid, "R8 incomplete 48-bit held back", 64'(insn_valid), 64'd0);
    step();
    do_flush();
    for (int n = 0; n < 6; n++) send_word(make_word());
    drain();
    do_flush();

    // Backpressure fills the buffer (R9, R10)
    hold_off = 1;
    step(); step();
    for (int n = 0; n < 4; n++) send_word(make_word());
    @(negedge clk);
    chk(!fetch_ready, "R9 ready drops when full", 64'(fetch_ready), 64'd0);
    chk(insn_valid, "R9 instruction offered when full", 64'(insn_valid), 64'd1);
    step();
    hold_off = 0;
    drain();
    do_flush();

    chk(seen[0] > 0, "R4 16-bit seen", 64'(seen[0]), 64'd1);
    chk(seen[1] > 0, "R7 32-bit seen", 64'(seen[1]), 64'd1);
    chk(seen[2] > 0, "R5 48-bit seen", 64'(seen[2]), 64'd1);
    chk(seen[3] > 0, "R6 64-bit seen", 64'(seen[3]), 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule